// File: doc/BRIEF.md
# Concurrent Pseudo-Random Memory Exerciser

This block generates heavy, overlapping traffic for a multi-port external memory controller so that weak supply, crosstalk or timing margins on the memory bus show up as data errors. Every controller port gets its own traffic engine. An engine first writes a pass of single-word accesses whose addresses and data come from a 32-bit shift-register sequence. It then reloads that sequence from the same seed and reads the same addresses back in the same order. Each returned word is compared against the regenerated value.

All engines run at the same time, so the controller sees requests for several regions at once. It can then overlap address transfers, data transfers and bank precharges. The engines use only single-word transfers, which keeps the block usable with controllers that cannot do bursts. Read data comes back on a separate strobe, and each engine keeps up to four expected words in flight, so the controller's read latency does not matter.

When every engine has finished its pass, the pass counter advances and each seed is rotated. The next pass then starts on its own. Each engine keeps a sticky error flag and a saturating error count. It also holds the address, expected word and received word of its first mismatch.

Top module: `mem_stress_tester`

## Requirements
- R1: While reset is asserted (asynchronously, active low), every request is low, the pass count is 0, and all error flags and error counts are 0.
- R2: In every pass, each port issues exactly 2^LOG2_OPS write requests (write enable 1) followed by exactly 2^LOG2_OPS read requests (write enable 0), each moving one word.
- R3: Generator state s steps as next(s) = {s[30:0], s[31]^s[21]^s[1]^s[0]}. Access k of a phase (k = 0 first) uses state s_k, with s_0 = the pass seed and s_(k+1) = next(next(s_k)). For port p its address is {p (PW bits), s_k[AW-PW-1:LOG2_OPS], k XOR seed[LOG2_OPS-1:0]}, and its write data is next(s_k)[DW-1:0].
- R4: The read phase restarts the generator from the pass seed, so it visits the written addresses in the written order and expects the written data.
- R5: A request that is not acknowledged stays asserted, with address, write enable and write data unchanged, until the acknowledge arrives.
- R6: A port never has more than FIFO_DEPTH (4) reads acknowledged whose data has not yet returned on the read-valid strobe.
- R7: Each word returned on read-valid is compared with the oldest outstanding expected word. A mismatch raises that port's sticky error flag and adds one to its error count, which saturates at 2^ECW-1.
- R8: A port's first mismatch latches its address, expected word and received word. Later mismatches leave these values unchanged.
- R9: The pass count rises by exactly one when every port has finished both phases and received all its read data. The next pass then starts with each seed rotated left by one bit. The initial seed of port p is SEED0 + p*SEED_STEP, defaulting to 32'h1D872B41 + p*32'h0F1E2D3C.
- R10: The ports run concurrently, so requests from different ports are pending in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | NPORTS | Per-port request |
| mem_we | output | NPORTS | Per-port write enable (1 = write) |
| mem_addr | output | NPORTS*AW | Per-port word address, port p at bits [p*AW +: AW] |
| mem_wdata | output | NPORTS*DW | Per-port write data |
| mem_ack | input | NPORTS | Per-port acknowledge pulse, accepts the pending request |
| mem_rvalid | input | NPORTS | Per-port read data valid strobe |
| mem_rdata | input | NPORTS*DW | Per-port read data |
| pass_count | output | PCW | Completed passes |
| err_flag | output | NPORTS | Sticky per-port mismatch flag |
| err_count | output | NPORTS*ECW | Saturating per-port mismatch count |
| first_addr | output | NPORTS*AW | Address of each port's first mismatch |
| first_exp | output | NPORTS*DW | Expected word of each port's first mismatch |
| first_got | output | NPORTS*DW | Received word of each port's first mismatch |

## Verification
A port's first request appears one cycle after the pass starts. Each acknowledge sampled at an edge moves the next address onto the bus right after that same edge. The error flag, error count and first-mismatch registers change on the edge that samples the read-valid strobe. The pass count rises two edges after the final read of the slowest port returns, and the next pass's requests follow one edge later. The bench's memory model drives acknowledge, read-valid and read data and samples every output at the falling edge, all from one process. It therefore compares each acknowledged request in the cycle it is accepted, and it reads the pass and error registers in the half-cycle after they settle, before the next pass issues anything.

// File: rtl/mst_pkg.sv
package mst_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2,
    PH_DRAIN = 2'd3
  } phase_e;

  // One step of the 32-bit maximal-length sequence (taps 32,22,2,1)
  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // Per-port starting seed, never zero
  function automatic logic [31:0] seed_for(input logic [31:0] base,
                                           input logic [31:0] stride,
                                           input int unsigned idx);
    logic [31:0] v;
    v = base + stride * 32'(idx);
    if (v == 32'd0) v = 32'd1;
    return v;
  endfunction

endpackage

// File: rtl/mst_fifo.sv
module mst_fifo #(
  parameter int unsigned W     = 28,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [PW:0]   cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  // storage carries no reset
  always_ff @(posedge clk) begin
    if (push) slot_q[wp_q] <= din;
  end

  assign dout  = slot_q[rp_q];
  assign full  = (cnt_q == (PW+1)'(DEPTH));
  assign empty = (cnt_q == '0);

  // R6: no write into a full queue unless a slot frees in the same cycle
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));

  // R6: occupancy never exceeds the outstanding-read limit
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (PW+1)'(DEPTH));

  // R7: a returned word always has an expected entry to match
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/mst_port.sv
module mst_port
  import mst_pkg::*;
#(
  parameter int unsigned AW      = 12,
  parameter int unsigned DW      = 16,
  parameter int unsigned NW      = 4,
  parameter int unsigned PW      = 1,
  parameter int unsigned PORT_ID = 0,
  parameter int unsigned ECW     = 16,
  parameter int unsigned DEPTH   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [31:0]    seed,
  output logic           req,
  output logic           we,
  output logic [AW-1:0]  addr,
  output logic [DW-1:0]  wdata,
  input  logic           ack,
  input  logic           rvalid,
  input  logic [DW-1:0]  rdata,
  output logic           busy,
  output logic           err_flag,
  output logic [ECW-1:0] err_cnt,
  output logic [AW-1:0]  fm_addr,
  output logic [DW-1:0]  fm_exp,
  output logic [DW-1:0]  fm_got
);

  localparam int unsigned RB = AW - PW - NW;
  localparam logic [PW-1:0]  PID   = PW'(PORT_ID);
  localparam logic [ECW-1:0] ECMAX = '1;
  localparam logic [NW-1:0]  LAST  = '1;

  phase_e         ph_q, ph_d;
  logic [31:0]    lfsr_q, lfsr_d, seed_q, seed_d, step1, step2;
  logic [NW-1:0]  idx_q, idx_d;
  logic           lfsr_en;
  logic           xfer, last;
  logic           q_push, q_pop, q_full, q_empty;
  logic [AW+DW-1:0] q_din, q_dout;
  logic [AW-1:0]  exp_addr;
  logic [DW-1:0]  exp_data;
  logic           mismatch;
  logic           err_flag_q, err_flag_d;
  logic [ECW-1:0] err_cnt_q, err_cnt_d;
  logic           cnt_en, first_en;
  logic [AW-1:0]  fm_addr_q;
  logic [DW-1:0]  fm_exp_q, fm_got_q;

  // ---------------- generator and request ----------------
  assign step1 = lfsr_step(lfsr_q);
  assign step2 = lfsr_step(step1);
  assign last  = (idx_q == LAST);

  assign addr  = {PID, lfsr_q[RB+NW-1:NW], idx_q ^ seed_q[NW-1:0]};
  assign wdata = step1[DW-1:0];
  assign we    = (ph_q == PH_WRITE);
  assign req   = (ph_q == PH_WRITE) || ((ph_q == PH_READ) && !q_full);
  assign xfer  = req && ack;
  assign busy  = (ph_q != PH_IDLE);

  always_comb begin
    ph_d    = ph_q;
    lfsr_d  = lfsr_q;
    seed_d  = seed_q;
    idx_d   = idx_q;
    lfsr_en = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (go) begin
          ph_d    = PH_WRITE;
          lfsr_d  = seed;
          seed_d  = seed;
          idx_d   = '0;
          lfsr_en = 1'b1;
        end
      end
      PH_WRITE: begin
        if (xfer) begin
          idx_d   = idx_q + 1'b1;
          lfsr_en = 1'b1;
          if (last) begin
            ph_d   = PH_READ;
            lfsr_d = seed_q;
          end else begin
            lfsr_d = step2;
          end
        end
      end
      PH_READ: begin
        if (xfer) begin
          idx_d   = idx_q + 1'b1;
          lfsr_d  = step2;
          lfsr_en = 1'b1;
          if (last) ph_d = PH_DRAIN;
        end
      end
      PH_DRAIN: begin
        if (q_empty) ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      lfsr_q <= '0;
      seed_q <= '0;
      idx_q  <= '0;
    end else begin
      ph_q <= ph_d;
      if (lfsr_en) begin
        lfsr_q <= lfsr_d;
        idx_q  <= idx_d;
      end
      if (go && (ph_q == PH_IDLE)) seed_q <= seed_d;
    end
  end

  // ---------------- expected-value queue ----------------
  assign q_push = xfer && (ph_q == PH_READ);
  assign q_pop  = rvalid && !q_empty;
  assign q_din  = {addr, step1[DW-1:0]};
  assign {exp_addr, exp_data} = q_dout;

  mst_fifo #(.W(AW + DW), .DEPTH(DEPTH)) u_expq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .pop   (q_pop),
    .din   (q_din),
    .dout  (q_dout),
    .full  (q_full),
    .empty (q_empty)
  );

  // ---------------- comparison and error record ----------------
  assign mismatch = q_pop && (rdata != exp_data);

  always_comb begin
    err_flag_d = err_flag_q | mismatch;
    err_cnt_d  = err_cnt_q + 1'b1;
    cnt_en     = mismatch && (err_cnt_q != ECMAX);
    first_en   = mismatch && !err_flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag_q <= 1'b0;
      err_cnt_q  <= '0;
      fm_addr_q  <= '0;
      fm_exp_q   <= '0;
      fm_got_q   <= '0;
    end else begin
      err_flag_q <= err_flag_d;
      if (cnt_en) err_cnt_q <= err_cnt_d;
      if (first_en) begin
        fm_addr_q <= exp_addr;
        fm_exp_q  <= exp_data;
        fm_got_q  <= rdata;
      end
    end
  end

  assign err_flag = err_flag_q;
  assign err_cnt  = err_cnt_q;
  assign fm_addr  = fm_addr_q;
  assign fm_exp   = fm_exp_q;
  assign fm_got   = fm_got_q;

  // R5: an unaccepted request holds all its fields
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(addr) && $stable(we) && $stable(wdata)));

  // R4: read phase begins from the pass seed at index zero
  a_r4_replay_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_READ) && ($past(ph_q) == PH_WRITE)) |-> ((lfsr_q == seed_q) && (idx_q == '0)));

  // R7: error flag is sticky
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R7: error count holds at its ceiling
  a_r7_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == ECMAX) |=> (err_cnt == ECMAX));

  // R8: first-mismatch record frozen once the flag is up
  a_r8_first_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> ($stable(fm_addr) && $stable(fm_exp) && $stable(fm_got)));

endmodule

// File: rtl/mem_stress_tester.sv
module mem_stress_tester
  import mst_pkg::*;
#(
  parameter int unsigned NPORTS    = 2,
  parameter int unsigned AW        = 12,
  parameter int unsigned DW        = 16,
  parameter int unsigned LOG2_OPS  = 4,
  parameter int unsigned ECW       = 16,
  parameter int unsigned PCW       = 16,
  parameter int unsigned DEPTH     = 4,
  parameter logic [31:0] SEED0     = 32'h1D87_2B41,
  parameter logic [31:0] SEED_STEP = 32'h0F1E_2D3C
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [NPORTS-1:0]     mem_req,
  output logic [NPORTS-1:0]     mem_we,
  output logic [NPORTS*AW-1:0]  mem_addr,
  output logic [NPORTS*DW-1:0]  mem_wdata,
  input  logic [NPORTS-1:0]     mem_ack,
  input  logic [NPORTS-1:0]     mem_rvalid,
  input  logic [NPORTS*DW-1:0]  mem_rdata,
  output logic [PCW-1:0]        pass_count,
  output logic [NPORTS-1:0]     err_flag,
  output logic [NPORTS*ECW-1:0] err_count,
  output logic [NPORTS*AW-1:0]  first_addr,
  output logic [NPORTS*DW-1:0]  first_exp,
  output logic [NPORTS*DW-1:0]  first_got
);

  localparam int unsigned PW = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  logic              run_q, run_d;
  logic [PCW-1:0]    pass_q, pass_d;
  logic [31:0]       seeds_q [NPORTS];
  logic [NPORTS-1:0] busy;
  logic              go, pass_done;

  // ---------------- pass sequencer ----------------
  assign go        = !run_q;
  assign pass_done = run_q && (busy == '0);

  always_comb begin
    run_d  = run_q;
    pass_d = pass_q + 1'b1;
    if (go)             run_d = 1'b1;
    else if (pass_done) run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pass_q <= '0;
      for (int p = 0; p < int'(NPORTS); p++) seeds_q[p] <= seed_for(SEED0, SEED_STEP, p);
    end else begin
      run_q <= run_d;
      if (pass_done) begin
        pass_q <= pass_d;
        for (int p = 0; p < int'(NPORTS); p++) seeds_q[p] <= {seeds_q[p][30:0], seeds_q[p][31]};
      end
    end
  end

  assign pass_count = pass_q;

  // ---------------- per-port engines ----------------
  for (genvar g = 0; g < int'(NPORTS); g++) begin : g_port
    mst_port #(
      .AW(AW), .DW(DW), .NW(LOG2_OPS), .PW(PW),
      .PORT_ID(g), .ECW(ECW), .DEPTH(DEPTH)
    ) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .seed     (seeds_q[g]),
      .req      (mem_req[g]),
      .we       (mem_we[g]),
      .addr     (mem_addr[g*AW +: AW]),
      .wdata    (mem_wdata[g*DW +: DW]),
      .ack      (mem_ack[g]),
      .rvalid   (mem_rvalid[g]),
      .rdata    (mem_rdata[g*DW +: DW]),
      .busy     (busy[g]),
      .err_flag (err_flag[g]),
      .err_cnt  (err_count[g*ECW +: ECW]),
      .fm_addr  (first_addr[g*AW +: AW]),
      .fm_exp   (first_exp[g*DW +: DW]),
      .fm_got   (first_got[g*DW +: DW])
    );
  end

  // R9: pass count moves only by one and only when every port is idle
  a_r9_pass_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_q != $past(pass_q)) |-> ((pass_q == $past(pass_q) + 1'b1) && ($past(busy) == '0)));

  // R9: a new pass is only launched into idle ports
  a_r9_go_idle: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (busy == '0));

  // R2: requests come only from running engines
  a_r2_req_in_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req != '0) |-> run_q);

endmodule

// File: tb/sim_mem_stress_tester.sv
module sim_mem_stress_tester;

  localparam int CLK_PERIOD = 10;
  localparam int NP  = 2;
  localparam int AW  = 12;
  localparam int DW  = 16;
  localparam int LN  = 4;
  localparam int ECW = 5;
  localparam int PCW = 16;
  localparam int OPS = 1 << LN;
  localparam int RB  = AW - 1 - LN;
  localparam logic [31:0] S0  = 32'h1D87_2B41;
  localparam logic [31:0] SST = 32'h0F1E_2D3C;

  // rows: ack_max, lat_max, fault mode, passes, expected errors port0, port1
  localparam int NROWS = 4;
  localparam int TBL [NROWS][6] = '{
    '{0, 0, 0, 2, 0, 0},
    '{2, 3, 0, 3, 0, 0},
    '{3, 4, 1, 2, 1, 0},
    '{1, 2, 2, 4, 0, 31}
  };

  logic                 clk;
  logic                 rst_n;
  logic [NP-1:0]        mem_req, mem_we, mem_ack, mem_rvalid, err_flag;
  logic [NP*AW-1:0]     mem_addr, first_addr;
  logic [NP*DW-1:0]     mem_wdata, mem_rdata, first_exp, first_got;
  logic [PCW-1:0]       pass_count;
  logic [NP*ECW-1:0]    err_count;

  mem_stress_tester #(
    .NPORTS(NP), .AW(AW), .DW(DW), .LOG2_OPS(LN), .ECW(ECW), .PCW(PCW)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .pass_count(pass_count), .err_flag(err_flag), .err_count(err_count),
    .first_addr(first_addr), .first_exp(first_exp), .first_got(first_got)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // memory model state
  logic [DW-1:0] mem [0:(1<<AW)-1];
  int  ack_max, lat_max, mode;
  int  cyc;
  int  wt [NP];
  int  qd [NP][16];
  int  qt [NP][16];
  int  qh [NP], qtl [NP], qlen [NP];
  logic [31:0] el [NP], bs [NP];
  int  eop [NP];
  bit  pv_req [NP];
  logic [AW-1:0] pv_addr [NP];
  logic pv_we [NP];
  logic [DW-1:0] pv_wd [NP];
  int  wr_seen [NP], rd_seen [NP], ret_seen [NP];
  int  stream_bad, hold_bad, outst_bad, pc_bad, drain_bad;
  bit  both_req, shot;
  int  last_pc;
  logic [AW-1:0] fa;
  logic [DW-1:0] fe, fg;

  function automatic logic [31:0] nx(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic step_cycle();
    @(negedge clk);
    cyc++;
    for (int p = 0; p < NP; p++) begin
      logic [AW-1:0] a, ea;
      logic [DW-1:0] d;
      logic [31:0] s1;
      logic [LN-1:0] k;
      bit ewe;
      a = mem_addr[p*AW +: AW];
      if (!rst_n) begin
        mem_ack[p] = 1'b0; mem_rvalid[p] = 1'b0; mem_rdata[p*DW +: DW] = '0;
        wt[p] = 0; qh[p] = 0; qtl[p] = 0; qlen[p] = 0; eop[p] = 0;
        bs[p] = S0 + SST * 32'(p); el[p] = bs[p]; pv_req[p] = 0;
        continue;
      end
      // R5: pending request must be unchanged
      if (pv_req[p] && !mem_ack[p]) begin
        if (!mem_req[p] || a != pv_addr[p] || mem_we[p] != pv_we[p] ||
            mem_wdata[p*DW +: DW] != pv_wd[p]) hold_bad++;
      end
      pv_req[p] = mem_req[p]; pv_addr[p] = a; pv_we[p] = mem_we[p];
      pv_wd[p] = mem_wdata[p*DW +: DW];
      mem_ack[p] = 1'b0;
      if (mem_req[p]) begin
        if (wt[p] != 0) wt[p]--;
        else begin
          mem_ack[p] = 1'b1;
          wt[p] = $urandom_range(ack_max, 0);
          k = LN'(eop[p] % OPS);
          if (k == '0) el[p] = bs[p];
          s1  = nx(el[p]);
          ea  = {1'(p), el[p][RB+LN-1:LN], k ^ bs[p][LN-1:0]};
          ewe = (eop[p] < OPS);
          if (a != ea || mem_we[p] != ewe || (ewe && mem_wdata[p*DW +: DW] != s1[DW-1:0]))
            stream_bad++;
          el[p] = nx(s1);
          eop[p]++;
          if (ewe) begin
            mem[a] = mem_wdata[p*DW +: DW];
            wr_seen[p]++;
          end else begin
            if (qlen[p] >= 4) outst_bad++;
            d = mem[a];
            if (mode == 1 && p == 0 && !shot && k == 4'd5) begin
              fa = a; fe = d; d = d ^ 16'h0004; fg = d; shot = 1;
            end
            if (mode == 2 && p == 1 && k[0]) begin
              if (!shot) begin fa = a; fe = d; fg = d ^ 16'h8000; shot = 1; end
              d = d ^ 16'h8000;
            end
            if (qlen[p] < 16) begin
              qd[p][qtl[p]] = int'(d);
              qt[p][qtl[p]] = cyc + 1 + $urandom_range(lat_max, 0);
              qtl[p] = (qtl[p] + 1) % 16;
              qlen[p]++;
            end
            rd_seen[p]++;
          end
          if (eop[p] == 2*OPS) begin
            eop[p] = 0;
            bs[p] = {bs[p][30:0], bs[p][31]};
          end
        end
      end
      mem_rvalid[p] = 1'b0;
      if (qlen[p] > 0 && qt[p][qh[p]] <= cyc) begin
        mem_rvalid[p] = 1'b1;
        mem_rdata[p*DW +: DW] = DW'(qd[p][qh[p]]);
        qh[p] = (qh[p] + 1) % 16;
        qlen[p]--;
        ret_seen[p]++;
      end
    end
    if (rst_n) begin
      if (mem_req == '1) both_req = 1;
      if (int'(pass_count) != last_pc) begin
        if (int'(pass_count) != last_pc + 1) pc_bad++;
        if (qlen[0] + qlen[1] != 0) drain_bad++;
      end
      last_pc = int'(pass_count);
    end else last_pc = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) step_cycle();
    check(mem_req == '0, "R1", "requests in reset", mem_req, 0);
    check(pass_count == '0, "R1", "pass count in reset", pass_count, 0);
    check(err_flag == '0 && err_count == '0, "R1", "error state in reset", err_count, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mem_ack = '0; mem_rvalid = '0; mem_rdata = '0; cyc = 0;
    ack_max = 0; lat_max = 0; mode = 0;
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;

    for (int r = 0; r < NROWS; r++) begin
      int guard;
      ack_max = TBL[r][0]; lat_max = TBL[r][1]; mode = TBL[r][2];
      stream_bad = 0; hold_bad = 0; outst_bad = 0; pc_bad = 0; drain_bad = 0;
      both_req = 0; shot = 0;
      for (int p = 0; p < NP; p++) begin wr_seen[p] = 0; rd_seen[p] = 0; ret_seen[p] = 0; end
      do_reset();
      guard = 0;
      while (int'(pass_count) < TBL[r][3] && guard < 20000) begin
        step_cycle();
        guard++;
      end
      check(int'(pass_count) == TBL[r][3], "R9", "passes completed", pass_count, TBL[r][3]);
      check(pc_bad == 0 && drain_bad == 0, "R9", "pass step and drain", pc_bad + drain_bad, 0);
      check(stream_bad == 0, "R3", "address/data stream incl. rotated seeds", stream_bad, 0);
      for (int p = 0; p < NP; p++) begin
        check(wr_seen[p] == TBL[r][3]*OPS, "R2", "writes per port", wr_seen[p], TBL[r][3]*OPS);
        check(rd_seen[p] == TBL[r][3]*OPS, "R4", "reads per port", rd_seen[p], TBL[r][3]*OPS);
        check(ret_seen[p] == rd_seen[p], "R9", "reads returned before pass", ret_seen[p], rd_seen[p]);
        check(int'(err_count[p*ECW +: ECW]) == TBL[r][4+p], "R7", "error count",
              err_count[p*ECW +: ECW], TBL[r][4+p]);
        check(err_flag[p] == (TBL[r][4+p] != 0), "R7", "error flag", err_flag[p], TBL[r][4+p] != 0);
      end
      check(hold_bad == 0, "R5", "request held until ack", hold_bad, 0);
      check(outst_bad == 0, "R6", "outstanding reads within four", outst_bad, 0);
      check(both_req, "R10", "ports requesting together", both_req, 1);
      if (mode != 0) begin
        int fp;
        fp = (mode == 1) ? 0 : 1;
        check(first_addr[fp*AW +: AW] == fa, "R8", "first mismatch address", first_addr[fp*AW +: AW], fa);
        check(first_exp[fp*DW +: DW] == fe, "R8", "first mismatch expected", first_exp[fp*DW +: DW], fe);
        check(first_got[fp*DW +: DW] == fg, "R8", "first mismatch received", first_got[fp*DW +: DW], fg);
      end
    end

    // directed: reset asserted in the middle of traffic drops requests at once (R1)
    mode = 0; ack_max = 2; lat_max = 1;
    do_reset();
    repeat (10) step_cycle();
    check(mem_req != '0, "R1", "traffic running before reset", mem_req, 3);
    rst_n = 1'b0;
    #1;
    check(mem_req == '0, "R1", "async reset clears requests", mem_req, 0);
    check(pass_count == '0, "R1", "async reset clears pass count", pass_count, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule